// File: doc/BRIEF.md
# Converter Serial Port with Data-Ready Output

This block is the device-side serial interface of a 16-bit converter. A host reaches it as a clocked serial slave through a chip select, a serial clock idling high, a data input, and one output line that does two jobs: it carries shifted-out register contents, and between transfers it shows an active-low "result ready" flag. Every transaction starts with a command byte that picks one of four registers and a direction. The four registers are status, mode, an auxiliary configuration byte and the conversion result.

A built-in conversion timer stands in for the analog path. Each time it completes, it captures the 16-bit `sample_in` bus as the new result. There are three ways to operate it. Continuous conversion is the default and produces a result every `CONV_CYCLES` clocks. A single conversion runs once, takes twice that long, and then parks the timer. Continuous read pushes every new result out of the port with no command byte. A run of 32 ones on the data input returns the whole interface to its defaults.

All port inputs are synchronised to `clk`, and serial clock edges are found by oversampling, so `sclk` must stay in each level for several `clk` periods.

Top module: `adc_serial_port`

## Requirements
- R1: After `rst_n` is released the mode field is 00 (continuous conversion), the ready flag is high (not ready), continuous read is off, and the mode and auxiliary registers read 0x00.
- R2: While `cs_n` is high, `dout_oe` is low. Raising `cs_n` partway through a command byte discards the bits already received, so the next byte after `cs_n` falls again is decoded as a fresh command.
- R3: `din` is sampled on rising `sclk`, and `dout` changes on falling `sclk`, MSB first. Command byte fields: bit 7 must be 0 or the byte is ignored; bits 5:4 pick the register (00 status, 01 mode, 10 auxiliary, 11 result); bit 3 is 1 for a read; bit 2 selects continuous read. A write to mode or auxiliary takes the next byte. Reads return 8 bits, except the result, which returns 16. Status reads as {ready_n, 00000, mode[7:6]}.
- R4: When the mode field is 00, a conversion completes every `CONV_CYCLES` clocks and stores `sample_in`. Outside a transfer, with `cs_n` low, `dout` shows the ready flag, which goes low when a result is stored.
- R5: A complete 16-bit read of the result register (command 0x38) sets the ready flag high. The result register can be read again, with the same value, until a new result is stored.
- R6: Writing mode bits 7:6 = 10 restarts the timer. One conversion then completes 2×`CONV_CYCLES` clocks later, after which the mode field becomes 11. No conversion happens while the field is 11 or 01.
- R7: Outside continuous read, a conversion that completes while a result read is loaded or in progress is discarded. The result register and the ready flag keep their values.
- R8: Command 0x3C (001111xx) enters continuous read. Each new result is presented on `dout` (ready low), and 16 `sclk` cycles shift it out with no command. After that the ready flag is high until the next result.
- R9: In continuous read, a result that has not been fully shifted out when the next conversion completes is replaced by the newer result.
- R10: In continuous read, only a byte 001110xx that completes while the ready flag is low leaves the mode. The same byte while the flag is high, and any other byte, is ignored.
- R11: 32 consecutive ones sampled on `din` (with `cs_n` low) reset the mode, auxiliary and result registers, the ready flag, continuous read and the timer to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from host |
| sample_in | input | DATA_W | Value captured as the result at each conversion |
| dout | output | 1 | Serial data out, or active-low ready flag between transfers |
| dout_oe | output | 1 | Drive enable for `dout` (low = high impedance) |

## Verification
The hardest situation to reach is a conversion finishing inside a result read, followed by proof that the new value was dropped. The first read was loaded before the conversion, so its own data cannot show the difference. The bench synchronises to a falling ready flag and changes `sample_in`. It then starts a read and holds `sclk` high partway through, so the transfer is still open when the next period ends. Straight after that, it reads again, before the following conversion. The second read must still return the old value, and the line must still show "not ready". Continuous-read overwrite is reached the same way: the bench deliberately lets one result go unread past the next period.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 2000,
  parameter int RST_ONES    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] sample_in,
  output logic              dout,
  output logic              dout_oe
);
  localparam int CNT_W = $clog2(2*CONV_CYCLES+1);
  localparam int BIT_W = $clog2(DATA_W+1);
  localparam int ONE_W = $clog2(RST_ONES+1);
  localparam logic [CNT_W-1:0] LIM_CONT = CNT_W'(CONV_CYCLES-1);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(2*CONV_CYCLES-1);
  localparam logic [7:0] MODE_DEF = 8'h00;
  localparam logic [7:0] AUX_DEF  = 8'h00;

  typedef enum logic [1:0] {S_CMD, S_WR, S_TX} st_t;

  logic [2:0]        sclk_q;
  logic [1:0]        cs_q, din_q;
  st_t               state;
  logic [7:0]        cmd_sr, mode_q, aux_q;
  logic [2:0]        cmd_cnt;
  logic [1:0]        wr_sel;
  logic [DATA_W-1:0] data_q, tx_sr;
  logic              tx_pend, tx_live, tx_len16, tx_is_data;
  logic [BIT_W-1:0]  tx_bits;
  logic              rdy_n, cread;
  logic [ONE_W-1:0]  ones;
  logic [CNT_W-1:0]  tcnt;

  wire       cs_act    = ~cs_q[1];
  wire       din_s     = din_q[1];
  wire       sclk_rise = cs_act &  sclk_q[1] & ~sclk_q[2];
  wire       sclk_fall = cs_act & ~sclk_q[1] &  sclk_q[2];
  wire [7:0] new_byte  = {cmd_sr[6:0], din_s};
  wire       byte_done = sclk_rise && cmd_cnt == 3'd7 && state != S_TX;
  wire       soft_rst  = sclk_rise && din_s && ones == ONE_W'(RST_ONES-1);
  wire [1:0] md        = mode_q[7:6];
  wire       conv_on   = md == 2'b00 || md == 2'b10;
  wire       conv_done = conv_on && tcnt == (md == 2'b10 ? LIM_ONE : LIM_CONT);
  wire       rd_busy   = (tx_pend | tx_live) & tx_is_data & ~cread;
  wire       tx_last   = sclk_rise && tx_live &&
                         tx_bits == (tx_len16 ? BIT_W'(DATA_W-1) : BIT_W'(7));
  wire       mode_wr   = byte_done && state == S_WR && wr_sel == 2'b01;
  wire [7:0] status    = {rdy_n, 5'b0, md};

  assign dout    = tx_live ? tx_sr[DATA_W-1] : rdy_n;
  assign dout_oe = cs_act;

  function automatic logic [DATA_W-1:0] pad8(input logic [7:0] b);
    return {b, {(DATA_W-8){1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b111; cs_q <= 2'b11; din_q <= 2'b00;
      state <= S_CMD; cmd_sr <= '0; cmd_cnt <= '0; wr_sel <= '0;
      mode_q <= MODE_DEF; aux_q <= AUX_DEF; data_q <= '0;
      tx_sr <= '0; tx_pend <= 1'b0; tx_live <= 1'b0; tx_len16 <= 1'b0;
      tx_is_data <= 1'b0; tx_bits <= '0;
      rdy_n <= 1'b1; cread <= 1'b0; ones <= '0; tcnt <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      din_q  <= {din_q[0], din};
      if (soft_rst) begin
        state <= S_CMD; cmd_sr <= '0; cmd_cnt <= '0; wr_sel <= '0;
        mode_q <= MODE_DEF; aux_q <= AUX_DEF; data_q <= '0;
        tx_pend <= 1'b0; tx_live <= 1'b0; tx_bits <= '0; tx_is_data <= 1'b0;
        rdy_n <= 1'b1; cread <= 1'b0; ones <= '0; tcnt <= '0;
      end else begin
        if (!cs_act)        ones <= '0;
        else if (sclk_rise) ones <= din_s ? ones + 1'b1 : '0;

        if (mode_wr)        tcnt <= '0;
        else if (!conv_on)  tcnt <= '0;
        else                tcnt <= conv_done ? '0 : tcnt + 1'b1;

        if (!cs_act) begin
          cmd_cnt <= '0;
          state   <= S_CMD;
          tx_live <= 1'b0;
          tx_pend <= tx_pend & cread;
        end else begin
          if (sclk_rise && state != S_TX) begin
            cmd_sr  <= new_byte;
            cmd_cnt <= cmd_cnt + 1'b1;
          end
          if (byte_done) begin
            if (state == S_WR) begin
              if (wr_sel == 2'b01) mode_q <= new_byte;
              else                 aux_q  <= new_byte;
              state <= S_CMD;
            end else if (cread) begin
              if (new_byte[7:2] == 6'b001110 && !rdy_n) cread <= 1'b0;
            end else if (!new_byte[7]) begin
              if (new_byte[3]) begin
                if (new_byte[5:4] == 2'b11 && new_byte[2]) begin
                  cread <= 1'b1;
                end else begin
                  state      <= S_TX;
                  tx_pend    <= 1'b1;
                  tx_live    <= 1'b0;
                  tx_bits    <= '0;
                  tx_is_data <= new_byte[5:4] == 2'b11;
                  tx_len16   <= new_byte[5:4] == 2'b11;
                  case (new_byte[5:4])
                    2'b00:   tx_sr <= pad8(status);
                    2'b01:   tx_sr <= pad8(mode_q);
                    2'b10:   tx_sr <= pad8(aux_q);
                    default: tx_sr <= data_q;
                  endcase
                end
              end else if (new_byte[5:4] == 2'b01 || new_byte[5:4] == 2'b10) begin
                state  <= S_WR;
                wr_sel <= new_byte[5:4];
              end
            end
          end
          if (sclk_fall) begin
            if (tx_pend) begin
              tx_live <= 1'b1;
              tx_pend <= 1'b0;
            end else if (tx_live) begin
              tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
          end
          if (sclk_rise && tx_live) begin
            tx_bits <= tx_bits + 1'b1;
            if (tx_last) begin
              tx_live <= 1'b0;
              if (state == S_TX) state <= S_CMD;
              if (tx_is_data) rdy_n <= 1'b1;
            end
          end
        end

        if (conv_done) begin
          if (md == 2'b10 && !mode_wr) mode_q[7:6] <= 2'b11;
          if (cread) begin
            data_q     <= sample_in;
            tx_sr      <= sample_in;
            tx_pend    <= 1'b1;
            tx_live    <= 1'b0;
            tx_bits    <= '0;
            tx_len16   <= 1'b1;
            tx_is_data <= 1'b1;
            rdy_n      <= 1'b0;
          end else if (!rd_busy) begin
            data_q <= sample_in;
            rdy_n  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module adc_serial_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              dout_oe,
  input logic              rdy_n,
  input logic              conv_done,
  input logic [1:0]        md,
  input logic [7:0]        mode_q,
  input logic              mode_wr,
  input logic              cread,
  input logic              soft_rst,
  input logic              rd_busy,
  input logic              tx_pend,
  input logic [DATA_W-1:0] data_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;

  assert_tristate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !dout_oe);

  assert_ready_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(conv_done));

  assert_single_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && md == 2'b10 && !mode_wr && !soft_rst) |=> md == 2'b11);

  assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && conv_done && !soft_rst) |=> $stable(data_q));

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cread && conv_done && !soft_rst) |=> (tx_pend && !rdy_n));

  assert_ones_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == 8'h00 && !cread && rdy_n));
endmodule

bind adc_serial_port adc_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_oe(dout_oe), .rdy_n(rdy_n),
  .conv_done(conv_done), .md(md), .mode_q(mode_q), .mode_wr(mode_wr),
  .cread(cread), .soft_rst(soft_rst), .rd_busy(rd_busy), .tx_pend(tx_pend),
  .data_q(data_q)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int CONV = 800;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, din = 0;
  logic [15:0] sample_in = 16'h0000;
  logic dout, dout_oe;
  int total = 0, bad = 0, cyc = 0;
  int t0, t1;

  adc_serial_port #(.DATA_W(16), .CONV_CYCLES(CONV), .RST_ONES(32)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL watchdog act=%0d exp<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [15:0] w, output logic [15:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 0; din = w[i];
      idle(8);
      r = {r[14:0], dout};
      sclk = 1;
      idle(8);
    end
    din = 0;
  endtask

  task automatic wr8(input logic [7:0] c, input logic [7:0] v);
    logic [15:0] r;
    xfer(8, {8'h0, c}, r);
    xfer(8, {8'h0, v}, r);
  endtask

  task automatic rd8(input logic [7:0] c, output logic [7:0] v);
    logic [15:0] r;
    xfer(8, {8'h0, c}, r);
    xfer(8, 16'h0, r);
    v = r[7:0];
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [15:0] r;
    xfer(8, 16'h0038, r);
    xfer(16, 16'h0, v);
  endtask

  task automatic wait_ready(input string req, output int t);
    int n = 0;
    while (dout !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
    t = cyc;
    if (n >= 4000) chk(req, 32'(dout), 32'h0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    idle(4);
    chk("R1 R2 tristate in reset", 32'(dout_oe), 32'h0);
    rst_n = 1; idle(10);
    chk("R2 tristate cs high", 32'(dout_oe), 32'h0);
    cs_n = 0; idle(10);
    chk("R1 drive when selected", 32'(dout_oe), 32'h1);
    chk("R1 ready high", 32'(dout), 32'h1);
    rd8(8'h08, v); chk("R3 status", 32'(v), 32'h80);
    rd8(8'h18, v); chk("R1 mode default", 32'(v), 32'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    logic [15:0] r;
    wr8(8'h20, 8'h5A);
    rd8(8'h28, v); chk("R3 aux write/read", 32'(v), 32'h5A);
    xfer(8, 16'h00A0, r);
    xfer(8, 16'h0033, r);
    rd8(8'h28, v); chk("R3 bit7 command ignored", 32'(v), 32'h5A);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    logic [15:0] r;
    xfer(4, 16'h0003, r);
    cs_n = 1; idle(10);
    chk("R2 tristate after abort", 32'(dout_oe), 32'h0);
    cs_n = 0; idle(10);
    rd8(8'h28, v); chk("R2 fresh command after abort", 32'(v), 32'h5A);
  endtask

  task automatic t_cont;
    logic [15:0] v;
    rd16(v);
    sample_in = 16'hA5C3;
    wait_ready("R4 first ready", t0);
    rd16(v); chk("R4 result value", 32'(v), 32'hA5C3);
    idle(2);
    chk("R5 ready high after read", 32'(dout), 32'h1);
    sample_in = 16'h1234;
    wait_ready("R4 second ready", t1);
    chk("R4 period", 32'(t1 - t0), 32'(CONV));
  endtask

  task automatic t_discard;
    logic [15:0] v, r;
    rd16(v); chk("R4 value 2", 32'(v), 32'h1234);
    sample_in = 16'hBEEF;
    xfer(8, 16'h0038, r);
    idle(250);
    xfer(16, 16'h0, v); chk("R5 repeat read", 32'(v), 32'h1234);
    rd16(v); chk("R7 result kept", 32'(v), 32'h1234);
    idle(2);
    chk("R7 no ready from discarded", 32'(dout), 32'h1);
  endtask

  task automatic t_single;
    logic [15:0] v;
    logic [7:0] m;
    int tw, te;
    wait_ready("R4 ready before single", te);
    rd16(v);
    sample_in = 16'h0F0F;
    wr8(8'h10, 8'h80);
    tw = cyc;
    wait_ready("R6 single ready", te);
    chk("R6 single timing", 32'((te - tw) >= 2*CONV - 40 && (te - tw) <= 2*CONV + 40), 32'h1);
    rd16(v); chk("R6 single value", 32'(v), 32'h0F0F);
    rd8(8'h18, m); chk("R6 mode parked", 32'(m), 32'hC0);
    idle(2 * CONV + 200);
    chk("R6 no further conversion", 32'(dout), 32'h1);
  endtask

  task automatic t_cread;
    logic [15:0] v, r;
    int t;
    wr8(8'h10, 8'h00);
    sample_in = 16'h5A5A;
    xfer(8, 16'h003C, r);
    wait_ready("R8 stream ready", t);
    xfer(16, 16'h0, v); chk("R8 streamed value", 32'(v), 32'h5A5A);
    idle(2);
    chk("R8 read once", 32'(dout), 32'h1);
    sample_in = 16'h1111;
    wait_ready("R9 ready", t);
    sample_in = 16'h2222;
    idle(CONV + 100);
    xfer(16, 16'h0, v); chk("R9 overwrite", 32'(v), 32'h2222);
    xfer(8, 16'h0038, r);
    sample_in = 16'h3333;
    wait_ready("R10 ready", t);
    xfer(16, 16'h3800, v); chk("R10 exit while high ignored", 32'(v), 32'h3333);
    sample_in = 16'h4444;
    wait_ready("R10 ready after exit", t);
    xfer(16, 16'h0, v); chk("R10 no stream after exit", 32'(v), 32'h0000);
    rd16(v); chk("R10 command read after exit", 32'(v), 32'h4444);
  endtask

  task automatic t_softrst;
    logic [7:0] m;
    logic [15:0] r;
    wr8(8'h10, 8'h80);
    wr8(8'h20, 8'h76);
    rd8(8'h28, m); chk("R3 aux before ones", 32'(m), 32'h76);
    xfer(16, 16'hFFFF, r);
    xfer(16, 16'hFFFF, r);
    idle(4);
    chk("R11 ready high", 32'(dout), 32'h1);
    rd8(8'h18, m); chk("R11 mode default", 32'(m), 32'h00);
    rd8(8'h28, m); chk("R11 aux default", 32'(m), 32'h00);
  endtask

  initial begin
    t_reset;
    t_regs;
    t_abort;
    t_cont;
    t_discard;
    t_single;
    t_cread;
    t_softrst;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule